// File: doc/BRIEF.md
# Segmented Program Memory Address Unit

This unit turns 16-bit program offsets into 17-bit physical program memory addresses. It holds two segment selectors. The code selector applies to instruction fetches. The table selector applies to constant-table reads, such as load-from-code and compare-with-code operations. Each selector is an 8-bit register, and only its lowest bit is stored. The program space is therefore two 64 KB segments. All offset arithmetic stays inside the current segment: an offset or program counter that runs past FFFFH wraps around to 0000H and never carries into a selector.

The code selector cannot be reached by software writes. Only the following control-transfer events load it:

- a far transfer (jump, call, vectored call, far return)
- interrupt entry
- return from interrupt

The table selector is a byte-wide register on the internal special-function register bus, at address 0008H. On interrupt entry the unit presents the current code selector and program counter for stacking. On return from interrupt it reloads the selector from the value popped off the stack. The stacking and the reload of the selector happen only when the extended 128 KB mode is on.

Top module: `pmem_seg_addr`

## Requirements
- R1: After reset both selectors are 0. A fetch then returns `{1'b0, offset}`, and a read of the table register at 0008H returns 00H.
- R2: `phys_addr` is the selected segment bit followed by the 16 offset bits. When `acc_sel` is 0 (fetch) the code selector supplies the segment bit. When `acc_sel` is 1 (table) the table selector supplies it. The output is combinational, and every offset from 0000H to FFFFH maps inside its segment.
- R3: A cycle with `sfr_wr` high and `sfr_addr` = 0008H loads `sfr_wdata[0]` into the table selector at the next clock edge. `sfr_rdata` is `{7'b0, table bit}` while `sfr_rd` is high and `sfr_addr` = 0008H, and 00H otherwise. A write to any other address leaves the table selector unchanged.
- R4: Bits 7..1 of written values have no effect. Writing FEH gives table bit 0, and far segment 02H gives code bit 0. Bits 7..1 of `sfr_rdata` and `stk_seg` are always 0.
- R5: A `far_load` cycle loads `far_seg[0]` into the code selector at the next edge. A target segment above 1 acts as its bit 0.
- R6: The code selector keeps its value through any cycle with no `far_load`, no `int_entry`, and no `rti` while `mode_128k` is set. This holds for table register writes, wrapping offsets, and `rti` while `mode_128k` is clear.
- R7: While `int_entry` is high, `stk_pc` equals `pc_in` and `stk_seg` holds the code selector value from before that cycle. `stk_seg_valid` equals `mode_128k`. At the next edge the code selector is cleared to 0, because the vectors sit in segment 0.
- R8: When `rti` is high and `mode_128k` is set, `rti_seg[0]` is loaded into the code selector at the next edge. When `rti` is high and `mode_128k` is clear, the selector is unchanged.
- R9: When several events fall in the same cycle, priority is fixed. Interrupt entry comes first, then an enabled `rti`, then `far_load`. An `rti` while `mode_128k` is clear takes no part in the priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_128k | input | 1 | Extended 128 KB mode enable |
| acc_sel | input | 1 | Access kind: 0 fetch, 1 table read |
| acc_offset | input | 16 | Offset inside the segment |
| phys_addr | output | 17 | Physical program memory address |
| far_load | input | 1 | Far transfer strobe |
| far_seg | input | 8 | Far transfer target segment |
| int_entry | input | 1 | Interrupt entry strobe |
| pc_in | input | 16 | Current program counter |
| stk_seg_valid | output | 1 | Segment value is to be stacked |
| stk_seg | output | 8 | Code selector value for stacking |
| stk_pc | output | 16 | Program counter value for stacking |
| rti | input | 1 | Return-from-interrupt strobe |
| rti_seg | input | 8 | Segment value popped from the stack |
| sfr_addr | input | 16 | Register bus address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_rd | input | 1 | Register bus read strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data |

## Verification
The properties assume the event strobes change only between clock edges. They also assume no event arrives while the internal reset is still being released. The stimulus respects both. It drives every input shortly after a rising edge. It waits several cycles after releasing `rst_n` before issuing the first strobe. The offset sweeps never touch a strobe, so the hold property sees idle cycles between the deliberate loads. Both the collision cases and the disabled-mode returns are issued one event set per cycle.

// File: rtl/pmem_seg_pkg.sv
package pmem_seg_pkg;
  localparam int OFS_W     = 16;
  localparam int SEG_REG_W = 8;
  localparam int SEG_IMPL  = 1;
  localparam int SFR_AW    = 16;
  localparam int SFR_DW    = 8;
  localparam logic [SFR_AW-1:0] TBL_SFR_ADDR = 16'h0008;

  typedef enum logic [1:0] {
    CS_HOLD = 2'd0,
    CS_FAR  = 2'd1,
    CS_RTI  = 2'd2,
    CS_IRQ  = 2'd3
  } cs_src_e;

  typedef enum logic {
    ACC_FETCH = 1'b0,
    ACC_TABLE = 1'b1
  } acc_e;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/code_seg_reg.sv
module code_seg_reg
  import pmem_seg_pkg::*;
#(
  parameter int SEG_W   = SEG_REG_W,
  parameter int IMPL_W  = SEG_IMPL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ext,
  input  logic              irq_req,
  input  logic              rti_req,
  input  logic [SEG_W-1:0]  rti_seg,
  input  logic              far_req,
  input  logic [SEG_W-1:0]  far_seg,
  output logic [IMPL_W-1:0] cs_q
);
  cs_src_e           src;
  logic              cs_en;
  logic [IMPL_W-1:0] cs_d;
  logic              unused_hi;

  assign unused_hi = &{1'b0, rti_seg[SEG_W-1:IMPL_W], far_seg[SEG_W-1:IMPL_W]};

  // Event arbitration: interrupt entry first, enabled return next, far transfer last.
  always_comb begin
    if (irq_req)                  src = CS_IRQ;
    else if (rti_req && mode_ext) src = CS_RTI;
    else if (far_req)             src = CS_FAR;
    else                          src = CS_HOLD;
  end

  always_comb begin
    cs_en = (src != CS_HOLD);
    unique case (src)
      CS_IRQ:  cs_d = '0;
      CS_RTI:  cs_d = rti_seg[IMPL_W-1:0];
      CS_FAR:  cs_d = far_seg[IMPL_W-1:0];
      default: cs_d = cs_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cs_q <= '0;
    else if (cs_en) cs_q <= cs_d;
  end
endmodule

// File: rtl/table_seg_reg.sv
module table_seg_reg
  import pmem_seg_pkg::*;
#(
  parameter int               IMPL_W = SEG_IMPL,
  parameter int               AW     = SFR_AW,
  parameter int               DW     = SFR_DW,
  parameter logic [AW-1:0]    MY_ADDR = TBL_SFR_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     sfr_addr,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  output logic [IMPL_W-1:0] ts_q
);
  logic              hit;
  logic              ts_en;
  logic [IMPL_W-1:0] ts_d;
  logic              unused_hi;

  assign unused_hi = &{1'b0, sfr_wdata[DW-1:IMPL_W]};

  always_comb begin
    hit   = (sfr_addr == MY_ADDR);
    ts_en = hit && sfr_wr;
    ts_d  = sfr_wdata[IMPL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_q <= '0;
    else if (ts_en) ts_q <= ts_d;
  end

  always_comb begin
    if (hit && sfr_rd) sfr_rdata = {{(DW-IMPL_W){1'b0}}, ts_q};
    else               sfr_rdata = '0;
  end
endmodule

// File: rtl/seg_addr_mux.sv
module seg_addr_mux
  import pmem_seg_pkg::*;
#(
  parameter int IMPL_W = SEG_IMPL,
  parameter int OW     = OFS_W,
  localparam int PW    = IMPL_W + OW
) (
  input  logic              acc_sel,
  input  logic [IMPL_W-1:0] cs,
  input  logic [IMPL_W-1:0] ts,
  input  logic [OW-1:0]     offset,
  output logic [PW-1:0]     phys
);
  logic [IMPL_W-1:0] seg_sel;

  // The offset is never added into the segment field, so wrap stays in-segment.
  always_comb begin
    seg_sel = (acc_e'(acc_sel) == ACC_TABLE) ? ts : cs;
    phys    = {seg_sel, offset};
  end
endmodule

// File: rtl/pmem_seg_addr.sv
module pmem_seg_addr
  import pmem_seg_pkg::*;
#(
  parameter int OW     = OFS_W,
  parameter int SEG_W  = SEG_REG_W,
  parameter int IMPL_W = SEG_IMPL,
  parameter int AW     = SFR_AW,
  parameter int DW     = SFR_DW,
  parameter logic [AW-1:0] TBL_ADDR = TBL_SFR_ADDR,
  localparam int PW    = IMPL_W + OW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_128k,
  input  logic             acc_sel,
  input  logic [OW-1:0]    acc_offset,
  output logic [PW-1:0]    phys_addr,
  input  logic             far_load,
  input  logic [SEG_W-1:0] far_seg,
  input  logic             int_entry,
  input  logic [OW-1:0]    pc_in,
  output logic             stk_seg_valid,
  output logic [SEG_W-1:0] stk_seg,
  output logic [OW-1:0]    stk_pc,
  input  logic             rti,
  input  logic [SEG_W-1:0] rti_seg,
  input  logic [AW-1:0]    sfr_addr,
  input  logic             sfr_wr,
  input  logic             sfr_rd,
  input  logic [DW-1:0]    sfr_wdata,
  output logic [DW-1:0]    sfr_rdata
);
  logic              rst_core_n;
  logic [IMPL_W-1:0] cs_q;
  logic [IMPL_W-1:0] ts_q;

  seg_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  code_seg_reg #(.SEG_W(SEG_W), .IMPL_W(IMPL_W)) i_cs (
    .clk(clk), .rst_n(rst_core_n), .mode_ext(mode_128k),
    .irq_req(int_entry), .rti_req(rti), .rti_seg(rti_seg),
    .far_req(far_load), .far_seg(far_seg), .cs_q(cs_q)
  );

  table_seg_reg #(.IMPL_W(IMPL_W), .AW(AW), .DW(DW), .MY_ADDR(TBL_ADDR)) i_ts (
    .clk(clk), .rst_n(rst_core_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ts_q(ts_q)
  );

  seg_addr_mux #(.IMPL_W(IMPL_W), .OW(OW)) i_mux (
    .acc_sel(acc_sel), .cs(cs_q), .ts(ts_q), .offset(acc_offset), .phys(phys_addr)
  );

  // Stacking view uses the register value present before this cycle's update.
  always_comb begin
    stk_seg_valid = int_entry && mode_128k;
    stk_seg       = {{(SEG_W-IMPL_W){1'b0}}, cs_q};
    stk_pc        = pc_in;
  end
endmodule

// File: rtl/pmem_seg_sva.sv
module pmem_seg_sva #(
  parameter int OW     = 16,
  parameter int SEG_W  = 8,
  parameter int IMPL_W = 1,
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter logic [AW-1:0] TBL_ADDR = 16'h0008
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              mode_128k,
  input logic              acc_sel,
  input logic [OW-1:0]     acc_offset,
  input logic [IMPL_W+OW-1:0] phys_addr,
  input logic              far_load,
  input logic [SEG_W-1:0]  far_seg,
  input logic              int_entry,
  input logic [OW-1:0]     pc_in,
  input logic              stk_seg_valid,
  input logic [SEG_W-1:0]  stk_seg,
  input logic [OW-1:0]     stk_pc,
  input logic              rti,
  input logic [SEG_W-1:0]  rti_seg,
  input logic [AW-1:0]     sfr_addr,
  input logic              sfr_wr,
  input logic [DW-1:0]     sfr_wdata,
  input logic [DW-1:0]     sfr_rdata,
  input logic [IMPL_W-1:0] cs_q,
  input logic [IMPL_W-1:0] ts_q
);
  a_r2_addr_form: assert property (@(posedge clk) disable iff (!rst_core_n)
    phys_addr == {(acc_sel ? ts_q : cs_q), acc_offset});

  a_r3_tbl_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sfr_wr && sfr_addr == TBL_ADDR) |=> ts_q == $past(sfr_wdata[IMPL_W-1:0]));

  a_r4_rdata_upper: assert property (@(posedge clk) disable iff (!rst_core_n)
    sfr_rdata[DW-1:IMPL_W] == '0);

  a_r5_far_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    (far_load && !int_entry && !(rti && mode_128k)) |=> cs_q == $past(far_seg[IMPL_W-1:0]));

  a_r6_cs_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!far_load && !int_entry && !(rti && mode_128k)) |=> $stable(cs_q));

  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_core_n)
    int_entry |=> cs_q == '0);

  a_r7_stack_view: assert property (@(posedge clk) disable iff (!rst_core_n)
    int_entry |-> (stk_pc == pc_in && stk_seg_valid == mode_128k &&
                   stk_seg[SEG_W-1:IMPL_W] == '0));

  a_r8_rti_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rti && mode_128k && !int_entry) |=> cs_q == $past(rti_seg[IMPL_W-1:0]));
endmodule

bind pmem_seg_addr pmem_seg_sva #(
  .OW(OW), .SEG_W(SEG_W), .IMPL_W(IMPL_W), .AW(AW), .DW(DW), .TBL_ADDR(TBL_ADDR)
) i_sva (
  .clk(clk), .rst_core_n(rst_core_n), .mode_128k(mode_128k), .acc_sel(acc_sel),
  .acc_offset(acc_offset), .phys_addr(phys_addr), .far_load(far_load),
  .far_seg(far_seg), .int_entry(int_entry), .pc_in(pc_in),
  .stk_seg_valid(stk_seg_valid), .stk_seg(stk_seg), .stk_pc(stk_pc), .rti(rti),
  .rti_seg(rti_seg), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
  .sfr_rdata(sfr_rdata), .cs_q(cs_q), .ts_q(ts_q)
);

// File: tb/test_pmem_seg_addr.sv
module test_pmem_seg_addr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_128k, acc_sel, far_load, int_entry, rti, sfr_wr, sfr_rd;
  logic [15:0] acc_offset, pc_in, sfr_addr, stk_pc;
  logic [16:0] phys_addr;
  logic [7:0]  far_seg, rti_seg, sfr_wdata, sfr_rdata, stk_seg;
  logic        stk_seg_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmem_seg_addr i_pmem_seg_addr (
    .clk(clk), .rst_n(rst_n), .mode_128k(mode_128k), .acc_sel(acc_sel),
    .acc_offset(acc_offset), .phys_addr(phys_addr), .far_load(far_load),
    .far_seg(far_seg), .int_entry(int_entry), .pc_in(pc_in),
    .stk_seg_valid(stk_seg_valid), .stk_seg(stk_seg), .stk_pc(stk_pc), .rti(rti),
    .rti_seg(rti_seg), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_cs(input logic [7:0] v);
    far_load = 1'b1; far_seg = v; step(); far_load = 1'b0;
  endtask

  task automatic set_ts(input logic [7:0] v);
    sfr_wr = 1'b1; sfr_addr = 16'h0008; sfr_wdata = v; step(); sfr_wr = 1'b0;
  endtask

  task automatic get_cs(output logic b);
    acc_sel = 1'b0; #1; b = phys_addr[16];
  endtask

  task automatic get_ts(output logic b);
    acc_sel = 1'b1; #1; b = phys_addr[16];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic b;
    rst_n = 1'b0; mode_128k = 1'b0; acc_sel = 1'b0; far_load = 1'b0; int_entry = 1'b0;
    rti = 1'b0; sfr_wr = 1'b0; sfr_rd = 1'b0; acc_offset = '0; pc_in = '0;
    sfr_addr = '0; far_seg = '0; rti_seg = '0; sfr_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    acc_sel = 1'b0; acc_offset = 16'h1234; #1;
    chk("R1 fetch after reset", phys_addr, 32'h01234);
    acc_sel = 1'b1; #1;
    chk("R1 table after reset", phys_addr, 32'h01234);
    sfr_rd = 1'b1; sfr_addr = 16'h0008; #1;
    chk("R1 table reg read", sfr_rdata, 32'h00);
    sfr_rd = 1'b0;

    // R2 strided sweep of offsets in every selector combination
    for (int c = 0; c < 2; c++) begin
      for (int t = 0; t < 2; t++) begin
        set_cs(8'(c)); set_ts(8'(t));
        for (int o = 0; o <= 65536; o += 257) begin
          int ofs;
          ofs = (o > 65535) ? 65535 : o;
          acc_offset = 16'(ofs);
          acc_sel = 1'b0; #1;
          chk("R2 fetch address", phys_addr, 32'(c * 65536 + ofs));
          acc_sel = 1'b1; #1;
          chk("R2 table address", phys_addr, 32'(t * 65536 + ofs));
        end
      end
    end

    // R3 register bus decode
    set_ts(8'h00);
    sfr_wr = 1'b1; sfr_addr = 16'h0009; sfr_wdata = 8'h01; step(); sfr_wr = 1'b0;
    get_ts(b); chk("R3 other address write ignored", b, 0);
    set_ts(8'h01);
    get_ts(b); chk("R3 write loads table bit", b, 1);
    sfr_rd = 1'b1; sfr_addr = 16'h0008; #1; chk("R3 read at 0008H", sfr_rdata, 32'h01);
    sfr_addr = 16'h0009; #1; chk("R3 read elsewhere", sfr_rdata, 32'h00);
    sfr_rd = 1'b0; sfr_addr = 16'h0008; #1; chk("R3 no read strobe", sfr_rdata, 32'h00);

    // R4 upper bits ignored
    set_ts(8'hFE); get_ts(b); chk("R4 FEH gives table bit 0", b, 0);
    set_ts(8'hFF); sfr_rd = 1'b1; #1; chk("R4 read of FFH write", sfr_rdata, 32'h01);
    sfr_rd = 1'b0;
    set_cs(8'h02); get_cs(b); chk("R4 far 02H gives code bit 0", b, 0);

    // R5 far transfer
    set_cs(8'h03); get_cs(b); chk("R5 far 03H gives code bit 1", b, 1);
    set_cs(8'h00); get_cs(b); chk("R5 far 00H", b, 0);
    set_cs(8'h01);

    // R6 hold on unrelated activity
    set_ts(8'h00); set_ts(8'h01);
    acc_offset = 16'hFFFF; pc_in = 16'hFFFF; step(); acc_offset = 16'h0000; step();
    mode_128k = 1'b0; rti = 1'b1; rti_seg = 8'h00; step(); rti = 1'b0;
    get_cs(b); chk("R6 code bit held", b, 1);

    // R7 interrupt entry
    mode_128k = 1'b1; pc_in = 16'hABCD; int_entry = 1'b1; #1;
    chk("R7 stk_pc", stk_pc, 32'hABCD);
    chk("R7 stk_seg old value", stk_seg, 32'h01);
    chk("R7 stk_seg_valid mode on", stk_seg_valid, 1);
    step(); int_entry = 1'b0;
    get_cs(b); chk("R7 code cleared", b, 0);
    set_cs(8'h01);
    mode_128k = 1'b0; int_entry = 1'b1; #1;
    chk("R7 stk_seg_valid mode off", stk_seg_valid, 0);
    step(); int_entry = 1'b0;
    get_cs(b); chk("R7 code cleared mode off", b, 0);

    // R8 return from interrupt
    mode_128k = 1'b1; rti = 1'b1; rti_seg = 8'h01; step(); rti = 1'b0;
    get_cs(b); chk("R8 restore 1", b, 1);
    rti = 1'b1; rti_seg = 8'h02; step(); rti = 1'b0;
    get_cs(b); chk("R8 restore 02H as 0", b, 0);
    mode_128k = 1'b0; rti = 1'b1; rti_seg = 8'h01; step(); rti = 1'b0;
    get_cs(b); chk("R8 mode off unchanged", b, 0);

    // R9 priority
    mode_128k = 1'b1; int_entry = 1'b1; far_load = 1'b1; far_seg = 8'h01;
    rti = 1'b1; rti_seg = 8'h01; #1;
    chk("R9 stacked pre-update value", stk_seg, 32'h00);
    step(); int_entry = 1'b0; far_load = 1'b0; rti = 1'b0;
    get_cs(b); chk("R9 interrupt wins", b, 0);
    rti = 1'b1; rti_seg = 8'h01; far_load = 1'b1; far_seg = 8'h00; step();
    rti = 1'b0; far_load = 1'b0;
    get_cs(b); chk("R9 return beats far", b, 1);
    mode_128k = 1'b0; rti = 1'b1; rti_seg = 8'h01; far_load = 1'b1; far_seg = 8'h00; step();
    rti = 1'b0; far_load = 1'b0;
    get_cs(b); chk("R9 far wins when return disabled", b, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule